// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block produces the two comparison-rate pulses that a phase-locked frequency synthesizer feeds to its phase detector. On the feedback side, a fast input clock passes through a digital dual-modulus prescaler. The prescaler divides by either M or M+1. A swallow counter and a main counter steer its modulus so that one full feedback cycle lasts exactly M·N + A input clocks. With this arrangement the loop can settle on any integer ratio, not only multiples of M. The modulus pair is 64/65 or 128/129, chosen by a mode input.

On the reference side, a separate counter divides the reference clock by R and marks each comparison period with a one-clock pulse. The synthesized frequency then follows f_out = (M·N + A)·f_ref / R.

Each side runs in its own clock domain. Each side samples its ratio inputs only at its own cycle boundary, so the surrounding logic can rewrite the ratios at any time without producing a torn cycle.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While rstN is low, fpPulse, frPulse and modCtrl are all 0.
- R2: With smallModulus = 1 (M = 64), successive fpPulse pulses are 64·N + A clkIn cycles apart.
- R3: With smallModulus = 0 (M = 128), successive fpPulse pulses are 128·N + A clkIn cycles apart.
- R4: With A = 0, modCtrl stays 0 for the whole feedback cycle, and the cycle lasts M·N clkIn cycles.
- R5: modCtrl (1 = divide by M+1) goes high in the same clkIn cycle that fpPulse is high, and stays high for exactly A·(M+1) clkIn cycles of each feedback cycle.
- R6: fpPulse is high for exactly one clkIn cycle per feedback cycle.
- R7: A change of ratioN, ratioA or smallModulus in the middle of a feedback cycle leaves that cycle's length unchanged. The new values take effect from the next fpPulse onward.
- R8: Successive frPulse pulses are R clkRef cycles apart, and each frPulse lasts one clkRef cycle.
- R9: A change of ratioR in the middle of a reference period leaves that period's length unchanged. The new value takes effect from the next frPulse onward.
- R10: The largest legal swallow count, A = N − 1, gives a cycle of M·N + N − 1 clkIn cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Fast input clock to be divided |
| clkRef | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| ratioN | input | 11 | Main counter ratio N (3 to 2047) |
| ratioA | input | 7 | Swallow count A (0 to 127, below N) |
| ratioR | input | 14 | Reference ratio R (3 to 16383) |
| smallModulus | input | 1 | 1 selects 64/65, 0 selects 128/129 |
| fpPulse | output | 1 | One-clkIn-wide pulse at the end of each feedback cycle |
| frPulse | output | 1 | One-clkRef-wide pulse at the end of each reference period |
| modCtrl | output | 1 | Modulus control, 1 while the prescaler divides by M+1 |

## Verification
The feedback path is exercised with several settings. A small-modulus case with A of 3 and a large-modulus case with A of 1 separate the two moduli and confirm that the high time of modCtrl scales with A·(M+1). An A = 0 case confirms that the swallow phase can be skipped entirely. An A = N − 1 case reaches the edge where the swallow phase fills all but one prescaler period. Mid-cycle rewrites of N and R show that the cycle in progress keeps its old length, which would not hold if either counter reloaded from the live inputs. Reference ratios of 5, the minimum of 3, and a change from 7 to 4 confirm the reference period and the one-cycle width of frPulse.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // strobes from the sequencing control to the counting datapath
  typedef struct packed {
    logic load;     // start a new feedback cycle from the ratio inputs
    logic dec;      // count one finished prescaler period
    logic modHigh;  // prescaler divides by M+1
  } psd_strobe_t;

  // conditions reported back by the datapath
  typedef struct packed {
    logic preTick;      // last input clock of a prescaler period
    logic aIsOne;       // swallow counter on its final step
    logic nIsOne;       // main counter on its final step
    logic newANonZero;  // ratio input A is nonzero
  } psd_status_t;

endpackage

// File: rtl/psd_datapath.sv
module psd_datapath
  import psd_pkg::*;
#(
  parameter int N_W     = 11,
  parameter int A_W     = 7,
  parameter int M_SMALL = 64,
  parameter int M_LARGE = 128
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N_W-1:0] ratioN,
  input  logic [A_W-1:0] ratioA,
  input  logic           smallModulus,
  input  psd_strobe_t    strb,
  output psd_status_t    status
);

  localparam int PC_W = $clog2(M_LARGE + 2);

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] baseLast;
  logic [PC_W-1:0] lastVal;
  logic [A_W-1:0]  aCnt;
  logic [N_W-1:0]  nCnt;
  logic            useSmall;

  // last count value of the current prescaler period
  generate
    if (M_SMALL == M_LARGE) begin : g_single_modulus
      assign baseLast = PC_W'(M_SMALL - 1);
    end else begin : g_dual_modulus
      assign baseLast = useSmall ? PC_W'(M_SMALL - 1) : PC_W'(M_LARGE - 1);
    end
  endgenerate

  assign lastVal = baseLast + PC_W'(strb.modHigh);

  always_comb begin
    status.preTick     = (pc == lastVal);
    status.aIsOne      = (aCnt == A_W'(1));
    status.nIsOne      = (nCnt == N_W'(1));
    status.newANonZero = (ratioA != '0);
  end

  // prescaler: digital divide by M or M+1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
    end else if (strb.load || status.preTick) begin
      pc <= '0;
    end else begin
      pc <= pc + PC_W'(1);
    end
  end

  // swallow and main counters, ratios captured only at a cycle boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aCnt     <= '0;
      nCnt     <= '0;
      useSmall <= 1'b1;
    end else if (strb.load) begin
      aCnt     <= ratioA;
      nCnt     <= ratioN;
      useSmall <= smallModulus;
    end else if (strb.dec) begin
      nCnt <= nCnt - N_W'(1);
      if (aCnt != '0) begin
        aCnt <= aCnt - A_W'(1);
      end
    end
  end

  // R5: the wide modulus is only in force while swallow periods remain
  a_r5_high_needs_swallow: assert property (@(posedge clk) disable iff (!rstN)
    strb.modHigh |-> (aCnt != '0));

  // R5: the wide modulus only starts at the beginning of a prescaler period
  a_r5_rise_at_period_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.modHigh) |-> (pc == '0));

  // R2: every prescaler period restarts its count after the last clock
  a_r2_period_restart: assert property (@(posedge clk) disable iff (!rstN)
    status.preTick |=> (pc == '0));

endmodule

// File: rtl/psd_ctrl.sv
module psd_ctrl
  import psd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  psd_status_t status,
  output psd_strobe_t strb,
  output logic        fpPulse
);

  logic loaded;
  logic modHighQ;
  logic lastTick;

  assign lastTick = loaded && status.preTick && status.nIsOne;

  always_comb begin
    strb.load    = !loaded || lastTick;
    strb.dec     = loaded && status.preTick && !status.nIsOne;
    strb.modHigh = modHighQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loaded   <= 1'b0;
      modHighQ <= 1'b0;
      fpPulse  <= 1'b0;
    end else begin
      loaded  <= 1'b1;
      fpPulse <= lastTick;
      if (strb.load) begin
        modHighQ <= status.newANonZero;
      end else if (strb.dec && status.aIsOne) begin
        modHighQ <= 1'b0;
      end
    end
  end

  // R6: the comparison pulse never lasts two input clocks
  a_r6_fp_single: assert property (@(posedge clk) disable iff (!rstN)
    fpPulse |=> !fpPulse);

endmodule

// File: rtl/psd_ref_div.sv
module psd_ref_div #(
  parameter int R_W = 14
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [R_W-1:0] ratioR,
  output logic           frPulse
);

  logic [R_W-1:0] rCnt;
  logic           started;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rCnt    <= '0;
      started <= 1'b0;
      frPulse <= 1'b0;
    end else begin
      started <= 1'b1;
      frPulse <= started && (rCnt == '0);
      if (!started || rCnt == '0) begin
        rCnt <= ratioR - R_W'(1);
      end else begin
        rCnt <= rCnt - R_W'(1);
      end
    end
  end

  // R8: the reference pulse is a single reference clock wide
  a_r8_fr_single: assert property (@(posedge clk) disable iff (!rstN)
    frPulse |=> !frPulse);

endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import psd_pkg::*;
#(
  parameter int N_W     = 11,
  parameter int A_W     = 7,
  parameter int R_W     = 14,
  parameter int M_SMALL = 64,
  parameter int M_LARGE = 128
) (
  input  logic           clkIn,
  input  logic           clkRef,
  input  logic           rstN,
  input  logic [N_W-1:0] ratioN,
  input  logic [A_W-1:0] ratioA,
  input  logic [R_W-1:0] ratioR,
  input  logic           smallModulus,
  output logic           fpPulse,
  output logic           frPulse,
  output logic           modCtrl
);

  psd_strobe_t strb;
  psd_status_t status;

  psd_datapath #(
    .N_W(N_W), .A_W(A_W), .M_SMALL(M_SMALL), .M_LARGE(M_LARGE)
  ) datapath_i (
    .clk(clkIn), .rstN(rstN), .ratioN(ratioN), .ratioA(ratioA),
    .smallModulus(smallModulus), .strb(strb), .status(status)
  );

  psd_ctrl ctrl_i (
    .clk(clkIn), .rstN(rstN), .status(status), .strb(strb), .fpPulse(fpPulse)
  );

  psd_ref_div #(.R_W(R_W)) ref_i (
    .clk(clkRef), .rstN(rstN), .ratioR(ratioR), .frPulse(frPulse)
  );

  assign modCtrl = strb.modHigh;

endmodule

// File: tb/pulse_swallow_divider_tb_top.sv
module pulse_swallow_divider_tb_top;

  logic        clkIn = 1'b0;
  logic        clkRef = 1'b0;
  logic        rstN;
  logic [10:0] ratioN;
  logic [6:0]  ratioA;
  logic [13:0] ratioR;
  logic        smallModulus;
  logic        fpPulse, frPulse, modCtrl;

  int total = 0;
  int failed = 0;

  always #2.5 clkIn = ~clkIn;
  always #7 clkRef = ~clkRef;

  pulse_swallow_divider dut_i (
    .clkIn(clkIn), .clkRef(clkRef), .rstN(rstN), .ratioN(ratioN),
    .ratioA(ratioA), .ratioR(ratioR), .smallModulus(smallModulus),
    .fpPulse(fpPulse), .frPulse(frPulse), .modCtrl(modCtrl)
  );

  task automatic check(input int actual, input int expected, input string req, input string what);
    total++;
    if (actual != expected) begin
      failed++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - failed, total);
  endtask

  task automatic syncFp();
    @(negedge clkIn);
    while (!fpPulse) @(negedge clkIn);
  endtask

  // starts in an fpPulse cycle, ends in the next one
  task automatic countFp(output int period, output int modHi, output int width);
    period = 0; modHi = 0; width = 0;
    do begin
      if (fpPulse) width++;
      if (modCtrl) modHi++;
      period++;
      @(negedge clkIn);
    end while (!fpPulse);
  endtask

  task automatic syncFr();
    @(negedge clkRef);
    while (!frPulse) @(negedge clkRef);
  endtask

  task automatic countFr(output int period, output int width);
    period = 0; width = 0;
    do begin
      if (frPulse) width++;
      period++;
      @(negedge clkRef);
    end while (!frPulse);
  endtask

  task automatic t_reset();
    check(int'(fpPulse), 0, "R1", "fpPulse in reset");
    check(int'(frPulse), 0, "R1", "frPulse in reset");
    check(int'(modCtrl), 0, "R1", "modCtrl in reset");
  endtask

  task automatic t_small();
    int p, m, w;
    @(negedge clkIn);
    ratioN = 11'd5; ratioA = 7'd3; smallModulus = 1'b1;
    syncFp(); syncFp();
    countFp(p, m, w);
    check(p, 5 * 64 + 3, "R2", "period N=5 A=3 M=64");
    check(m, 3 * 65, "R5", "modCtrl high time M=64");
    check(w, 1, "R6", "fpPulse width");
  endtask

  task automatic t_large();
    int p, m, w;
    @(negedge clkIn);
    ratioN = 11'd4; ratioA = 7'd1; smallModulus = 1'b0;
    syncFp();
    countFp(p, m, w);
    check(p, 4 * 128 + 1, "R3", "period N=4 A=1 M=128");
    check(m, 129, "R5", "modCtrl high time M=128");
    check(w, 1, "R6", "fpPulse width M=128");
  endtask

  task automatic t_zero_a();
    int p, m, w;
    @(negedge clkIn);
    ratioN = 11'd3; ratioA = 7'd0; smallModulus = 1'b1;
    syncFp();
    countFp(p, m, w);
    check(p, 3 * 64, "R4", "period N=3 A=0");
    check(m, 0, "R4", "modCtrl high time A=0");
  endtask

  task automatic t_max_a();
    int p, m, w;
    @(negedge clkIn);
    ratioN = 11'd3; ratioA = 7'd2; smallModulus = 1'b0;
    syncFp();
    countFp(p, m, w);
    check(p, 3 * 128 + 2, "R10", "period N=3 A=2 M=128");
    check(m, 2 * 129, "R10", "modCtrl high time A=N-1");
  endtask

  task automatic t_mid_change();
    int cnt, p, m, w;
    @(negedge clkIn);
    ratioN = 11'd4; ratioA = 7'd1; smallModulus = 1'b1;
    syncFp(); syncFp();
    cnt = 0;
    do begin
      cnt++;
      if (cnt == 20) begin
        ratioN = 11'd6; smallModulus = 1'b0;
      end
      @(negedge clkIn);
    end while (!fpPulse);
    check(cnt, 4 * 64 + 1, "R7", "cycle in progress keeps old ratio");
    countFp(p, m, w);
    check(p, 6 * 128 + 1, "R7", "next cycle uses new ratio");
  endtask

  task automatic t_ref();
    int p, w;
    @(negedge clkRef);
    ratioR = 14'd5;
    syncFr(); syncFr();
    countFr(p, w);
    check(p, 5, "R8", "reference period R=5");
    check(w, 1, "R8", "frPulse width");
    ratioR = 14'd3;
    syncFr();
    countFr(p, w);
    check(p, 3, "R8", "reference period R=3");
  endtask

  task automatic t_ref_change();
    int cnt, p, w;
    @(negedge clkRef);
    ratioR = 14'd7;
    syncFr(); syncFr();
    cnt = 0;
    do begin
      cnt++;
      if (cnt == 2) ratioR = 14'd4;
      @(negedge clkRef);
    end while (!frPulse);
    check(cnt, 7, "R9", "reference period in progress keeps R=7");
    countFr(p, w);
    check(p, 4, "R9", "next reference period uses R=4");
  endtask

  initial begin
    repeat (150000) @(posedge clkIn);
    failed++; total++;
    $display("FAIL watchdog all requirements: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0;
    ratioN = 11'd5; ratioA = 7'd3; ratioR = 14'd5; smallModulus = 1'b1;
    repeat (4) @(negedge clkIn);
    t_reset();
    rstN = 1'b1;
    t_small();
    t_large();
    t_zero_a();
    t_max_a();
    t_mid_change();
    t_ref();
    t_ref_change();
    summary();
    $finish;
  end

endmodule